// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 PHY management transactions for an Ethernet MAC. Software writes a single 32-bit command word. That word carries the start pattern, the opcode, the PHY address, the register address, the turnaround pattern and, for writes, 16 bits of payload. The write launches the transaction at once. There is no separate go bit.

The block first sends a 32-bit preamble of ones, which is never suppressed. It then shifts the command word out on the management data line, MSB first, against a management clock. That clock is produced from the system clock by a programmable divisor. On a read the block releases the data line at the turnaround and captures the 16 bits the PHY returns. When the frame ends it sets a sticky completion flag, and software clears that flag by writing a 1 to it.

Software reaches the block through a small register port with three addresses:
- Address 0 is the command register on write and the captured read data on read.
- Address 1 holds the completion flag.
- Address 2 holds the clock divisor.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low, and reads of addresses 0, 1 and 2 all return 0.
- R2: A write to address 0 while idle starts a frame at once. Its first 32 bits, each sampled at an mdc rising edge, are ones.
- R3: After the preamble, the 32 bits of the command word are sent MSB first (bit 31 first). Each bit is held stable while mdc is high.
- R4: When command bits [29:28] equal 2'b10 (read), mdio_oe drops for the last 18 bit times, which are the two turnaround bits and the 16 data bits. Otherwise mdio_oe stays high for all 64 bits.
- R5: On a read, mdio_i is sampled at each of the last 16 mdc rising edges, MSB first. After completion, address 0 returns the 16 bits in [15:0] and zero in [31:16].
- R6: Address 2 bits [DIV_W-1:0] set the divisor S. mdc is high for S and low for S system clocks, giving a period of 2*S cycles.
- R7: While S is 0, mdc stays low and a pending frame does not advance. It resumes once S is made non-zero.
- R8: At the mdc falling edge that ends bit 64, bit 23 of address 1 becomes 1. mdc then stays low and mdio_oe is low.
- R9: A write to address 1 with bit 23 set clears the flag. A write with bit 23 clear leaves it set.
- R10: A write to address 0 during a frame is ignored. The frame on the line continues unchanged.
- R11: A write transaction leaves the value read from address 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 command/data, 1 flag, 2 divisor) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data driven onto the management line |
| mdio_oe | output | 1 | Drive enable for the management line |
| mdio_i | input | 1 | Data received from the management line |

## Verification
The bench decodes every frame bit at the mdc rising edges. It compares the decoded bits with the preamble and the command word, so a shifter that is off by one position or sends LSB first shows up as a bit mismatch. Read frames check that the line is released at exactly the turnaround. They also check that returned data lands in the register in the right order, which catches a capture taken on the wrong mdc edge or a release that is one bit late.

Further cases target the hazards:
- A second command write in the middle of a frame, which a design without a busy guard would let corrupt the line.
- A divisor of zero, which a naive counter would turn into a free-running or glitching clock.
- Write-one-to-clear handling of the flag, where writing 0 must leave the flag set.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PRE   = 32;
  localparam int FRAME = PRE + 32;
  localparam int CW    = $clog2(FRAME);
  localparam int EVT_BIT = 23;

  logic [DIV_W-1:0] speed_q, dcnt;
  logic [31:0]      cmd_q;
  logic [15:0]      data_q, cap_q;
  logic [CW-1:0]    bitcnt;
  logic             busy, mdc_q, evt_q;

  wire wr_cmd = reg_we && reg_addr == 2'd0;
  wire wr_evt = reg_we && reg_addr == 2'd1;
  wire wr_spd = reg_we && reg_addr == 2'd2;
  wire is_rd  = cmd_q[29:28] == 2'b10;
  wire tick   = busy && speed_q != '0 && dcnt >= speed_q - 1'b1;
  wire rise   = tick && !mdc_q;
  wire fall   = tick && mdc_q;
  wire last   = bitcnt == CW'(FRAME - 1);
  wire in_pre = bitcnt < CW'(PRE);
  wire [4:0] idx = ~bitcnt[4:0];

  assign mdc     = mdc_q;
  assign mdio_o  = busy && (in_pre || cmd_q[idx]);
  assign mdio_oe = busy && !(is_rd && bitcnt >= CW'(PRE + 14));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= '0;
      dcnt    <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      cap_q   <= '0;
      bitcnt  <= '0;
      busy    <= 1'b0;
      mdc_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (wr_spd) speed_q <= reg_wdata[DIV_W-1:0];

      if (!busy) begin
        if (wr_cmd) begin
          cmd_q  <= reg_wdata;
          busy   <= 1'b1;
          bitcnt <= '0;
          dcnt   <= '0;
          mdc_q  <= 1'b0;
        end
      end else if (speed_q == '0) begin
        dcnt  <= '0;
        mdc_q <= 1'b0;
      end else if (tick) begin
        dcnt  <= '0;
        mdc_q <= !mdc_q;
        if (rise && is_rd && bitcnt >= CW'(PRE + 16))
          cap_q <= {cap_q[14:0], mdio_i};
        if (fall) begin
          if (last) begin
            busy <= 1'b0;
            if (is_rd) data_q <= cap_q;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end

      if (fall && last)                      evt_q <= 1'b1;
      else if (wr_evt && reg_wdata[EVT_BIT]) evt_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {16'h0, data_q};
      2'd1:    reg_rdata = {8'h0, evt_q, 23'h0};
      2'd2:    reg_rdata = {{(32-DIV_W){1'b0}}, speed_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module mdio_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             evt_q,
  input logic [DIV_W-1:0] speed_q,
  input logic [31:0]      cmd_q
);
  a_r6_mdc_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r7_speed0_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_q == '0 && !(reg_we && reg_addr == 2'd2)) |=> !mdc);

  a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));

  a_r3_bit_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  a_r8_evt_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $fell(busy));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
  .evt_q(evt_q), .speed_q(speed_q), .cmd_q(cmd_q)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 0;

  int nchk = 0, nfail = 0;
  logic ob [64];
  logic eb [64];
  time  tr0, tr1, tf0;

  mdio_master dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic collect(input logic [15:0] phy, input bit inj, input logic [31:0] injcmd);
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      if (k == 0) tr0 = $time;
      if (k == 1) tr1 = $time;
      #1;
      ob[k] = mdio_o;
      eb[k] = mdio_oe;
      @(negedge mdc);
      if (k == 0) tf0 = $time;
      #1;
      if (k + 1 >= 48 && k + 1 <= 63) mdio_i = phy[63-(k+1)];
      else mdio_i = 1'b0;
      if (inj && k == 10) reg_wr(2'd0, injcmd);
    end
  endtask

  task automatic check_frame(input logic [31:0] cmd, input bit rd, input string req);
    int bad_pre = 0, bad_cmd = 0, bad_oe = 0;
    for (int k = 0; k < 64; k++) begin
      bit oe_exp = rd ? (k < 46) : 1'b1;
      if (eb[k] !== oe_exp) bad_oe++;
      if (oe_exp) begin
        if (k < 32 && ob[k] !== 1'b1) bad_pre++;
        if (k >= 32 && ob[k] !== cmd[63-k]) bad_cmd++;
      end
    end
    chk(bad_pre == 0, {req, " R2 preamble ones"}, bad_pre, 0);
    chk(bad_cmd == 0, {req, " R3 command bits MSB first"}, bad_cmd, 0);
    chk(bad_oe == 0, {req, " R4 drive enable pattern"}, bad_oe, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 mdc/oe low after reset", {mdc, mdio_oe}, 0);
    reg_rd(2'd0, d); chk(d === 0, "R1 data reg reset", d, 0);
    reg_rd(2'd1, d); chk(d === 0, "R1 flag reset", d, 0);
    reg_rd(2'd2, d); chk(d === 0, "R1 divisor reset", d, 0);
  endtask

  task automatic t_write_frame;
    logic [31:0] cmd = mk(2'b01, 5'h05, 5'h01, 16'hA5C3);
    logic [31:0] d;
    reg_wr(2'd2, 32'd4);
    reg_wr(2'd0, cmd);
    collect(16'h0, 0, 0);
    check_frame(cmd, 0, "write");
    chk(tr1 - tr0 == 160, "R6 period 2*S", 32'(tr1 - tr0), 160);
    chk(tf0 - tr0 == 80, "R6 high time S", 32'(tf0 - tr0), 80);
    reg_rd(2'd1, d); chk(d === 32'h0080_0000, "R8 flag set on finish", d, 32'h0080_0000);
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R8 line released", {mdc, mdio_oe}, 0);
    reg_rd(2'd0, d); chk(d === 0, "R11 write leaves data reg", d, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    reg_wr(2'd1, 32'hFF7F_FFFF);
    reg_rd(2'd1, d); chk(d === 32'h0080_0000, "R9 write 0 keeps flag", d, 32'h0080_0000);
    reg_wr(2'd1, 32'h0080_0000);
    reg_rd(2'd1, d); chk(d === 0, "R9 write 1 clears flag", d, 0);
  endtask

  task automatic t_read_frame(input logic [4:0] pa, input logic [15:0] phy, input int s);
    logic [31:0] cmd = mk(2'b10, pa, 5'h01, 16'h0);
    logic [31:0] d;
    reg_wr(2'd2, 32'(s));
    reg_wr(2'd0, cmd);
    collect(phy, 0, 0);
    check_frame(cmd, 1, "read");
    reg_rd(2'd0, d); chk(d === {16'h0, phy}, "R5 captured read data", d, {16'h0, phy});
    reg_rd(2'd1, d); chk(d === 32'h0080_0000, "R8 flag after read", d, 32'h0080_0000);
    reg_wr(2'd1, 32'h0080_0000);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] a = mk(2'b01, 5'h0A, 5'h1F, 16'h1234);
    logic [31:0] b = mk(2'b10, 5'h15, 5'h00, 16'hEDCB);
    logic [31:0] d;
    reg_wr(2'd2, 32'd2);
    reg_wr(2'd0, a);
    collect(16'h0, 1, b);
    check_frame(a, 0, "R10 mid-frame command ignored");
    repeat (20) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R10 no second frame", {mdc, mdio_oe}, 0);
    reg_rd(2'd0, d); chk(d === 32'h0000_8E15, "R11 data reg kept", d, 32'h0000_8E15);
    reg_wr(2'd1, 32'h0080_0000);
  endtask

  task automatic t_speed0;
    logic [31:0] cmd = mk(2'b01, 5'h11, 5'h04, 16'h0F0F);
    int seen = 0;
    reg_wr(2'd2, 32'd0);
    reg_wr(2'd0, cmd);
    repeat (100) begin
      @(negedge clk);
      if (mdc !== 1'b0) seen++;
    end
    chk(seen == 0, "R7 mdc held low at S=0", seen, 0);
    fork
      collect(16'h0, 0, 0);
      reg_wr(2'd2, 32'd5);
    join
    check_frame(cmd, 0, "R7 resumed frame");
    chk(tr1 - tr0 == 200, "R6 period at S=5", 32'(tr1 - tr0), 200);
    reg_wr(2'd1, 32'h0080_0000);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nchk + 1, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_frame;
    t_w1c;
    t_read_frame(5'h1F, 16'h7001, 3);
    t_read_frame(5'h03, 16'h8E15, 4);
    t_busy_ignore;
    t_speed0;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule